// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the low address bits for each beat of a four-beat memory burst. A burst-start strobe captures the whole incoming address and the order selection. After that, every clock edge on which the active-low advance input is low moves the low bits to the next beat. The upper bits stay at the value captured when the burst started. The sequence is the same for read and write bursts, so the block has no direction input.

Two orders are available. In interleaved order, beat k is the start value XOR k. In linear order, beat k is the start value plus k, modulo 4. Internally the block keeps a 2-bit beat count, a captured start value and a captured order bit. A small mapper combines them into the output address. A flag marks the fourth beat. One more advance after the fourth beat wraps back to the starting address.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and until the first burst start, `addr_o` is all zeros and `last_o` is 0.
- R2: A cycle with `start_i`=1 makes `addr_o` equal `addr_i` after the next rising edge, with `last_o`=0, even if `adv_n_i` is 0 in that same cycle (start wins over advance).
- R3: With `order_i`=1 (interleaved) sampled at start, beat k (k=0..3) shows low bits = start XOR k: start 00 gives 00,01,10,11; 01 gives 01,00,11,10; 10 gives 10,11,00,01; 11 gives 11,10,01,00.
- R4: With `order_i`=0 (linear) sampled at start, beat k shows low bits = (start + k) mod 4: start 01 gives 01,10,11,00; 10 gives 10,11,00,01; 11 gives 11,00,01,10.
- R5: A rising edge with `start_i`=0 and `adv_n_i`=1 leaves `addr_o` and `last_o` unchanged.
- R6: `last_o` is 1 exactly while the fourth beat (beat count 3) is presented.
- R7: An advance while the fourth beat is presented returns the low bits to the captured start value and clears `last_o`.
- R8: The bits of `addr_o` above the low field equal those of `addr_i` at burst start, whatever `addr_i` does later.
- R9: `order_i` is used only in a start cycle. Changing it during a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Burst start strobe; captures `addr_i` and `order_i` |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | Start address of the burst |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | High on the fourth beat |

## Verification
Some rules are checked by assertions on every clock edge:
- the load after a start strobe;
- holding when advance is high;
- the linear step of one;
- the XOR relation between the output, the captured start and the beat count;
- the wrap after the last beat;
- the stability of the upper bits during a burst.

Other behaviour only the bench scenarios can show. These are the complete four-beat sequences for every start value in both orders, the ignored order change mid-burst, and the return to zeros when reset is asserted in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned LOW_W = 2;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;

  typedef logic [LOW_W-1:0] low_t;
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic step_i,
  output low_t beat_o,
  output logic last_o
);
  low_t beat_q, beat_d;
  logic beat_en;

  always_comb begin
    beat_en = load_i | step_i;
    beat_d  = beat_q;
    if (load_i)      beat_d = '0;
    else if (step_i) beat_d = beat_q + low_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;
  assign last_o = &beat_q;

  // R7: a step on the final beat returns the count to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && last_o) |=> (beat_o == '0 && !last_o));
  // R2: a load clears the beat count
  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0));
endmodule

// File: rtl/bseq_addr_map.sv
module bseq_addr_map
  import burst_seq_pkg::*;
(
  input  order_e ord_i,
  input  low_t   base_i,
  input  low_t   beat_i,
  output low_t   low_o
);
  always_comb begin
    unique case (ord_i)
      ORD_INTERLEAVED: low_o = base_i ^ beat_i;
      default:         low_o = base_i + beat_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int unsigned HI_W = ADDR_W - LOW_W;

  logic   rst_n_s;
  low_t   base_q, base_d;
  logic [HI_W-1:0] hi_q, hi_d;
  order_e ord_q, ord_d;
  low_t   beat;
  low_t   low_addr;
  logic   step;

  bseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign step = !adv_n_i && !start_i;

  always_comb begin
    base_d = base_q;
    hi_d   = hi_q;
    ord_d  = ord_q;
    if (start_i) begin
      base_d = addr_i[LOW_W-1:0];
      hi_d   = addr_i[ADDR_W-1:LOW_W];
      ord_d  = order_e'(order_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q <= '0;
      hi_q   <= '0;
      ord_q  <= ORD_INTERLEAVED;
    end else if (start_i) begin
      base_q <= base_d;
      hi_q   <= hi_d;
      ord_q  <= ord_d;
    end
  end

  bseq_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (start_i),
    .step_i (step),
    .beat_o (beat),
    .last_o (last_o)
  );

  bseq_addr_map u_map (
    .ord_i  (ord_q),
    .base_i (base_q),
    .beat_i (beat),
    .low_o  (low_addr)
  );

  assign addr_o = {hi_q, low_addr};

  // R2: start captures the presented address, first beat is not last
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_i |=> (addr_o == $past(addr_i) && !last_o));
  // R5: no start and no advance keeps the outputs
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!start_i && adv_n_i) |=> ($stable(addr_o) && $stable(last_o)));
  // R4: a linear step adds one to the low field
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!start_i && !adv_n_i && ord_q == ORD_LINEAR)
      |=> (addr_o[LOW_W-1:0] == low_t'($past(addr_o[LOW_W-1:0]) + low_t'(1))));
  // R3: interleaved output XOR captured start equals the beat count
  p_xor_map_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ord_q == ORD_INTERLEAVED) |-> ((addr_o[LOW_W-1:0] ^ base_q) == beat));
  // R8: upper bits move only on a start
  p_upper_stable_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !start_i |=> $stable(addr_o[ADDR_W-1:LOW_W]));
  // R7: advancing off the last beat lands back on the start value
  p_wrap_base_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!start_i && !adv_n_i && last_o) |=> (addr_o[LOW_W-1:0] == base_q));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic adv_n_i = 1'b1;
  logic order_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic last_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .last_o(last_o)
  );

  // {order, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [0:7] = '{
    11'b1_00_00_01_10_11,
    11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01,
    11'b1_11_11_10_01_00,
    11'b0_00_00_01_10_11,
    11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01,
    11'b0_11_11_00_01_10
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_burst(input logic ord, input logic [AW-1:0] a, input logic adv_n);
    start_i = 1'b1; order_i = ord; addr_i = a; adv_n_i = adv_n;
    tick();
    start_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] up;
    logic [AW-1:0] held;
    // R1: reset state
    tick(); tick();
    check("R1 addr in reset", addr_o, '0);
    check("R1 last in reset", {15'b0, last_o}, '0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 addr after release", addr_o, '0);
    check("R1 last after release", {15'b0, last_o}, '0);

    // R3/R4/R6/R7/R8: vector walk
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      logic [1:0] ex [4];
      v = VEC[i];
      ex[0] = v[7:6]; ex[1] = v[5:4]; ex[2] = v[3:2]; ex[3] = v[1:0];
      up = AW'(i * 3 + 5) << 2;
      begin_burst(v[10], up | AW'(v[9:8]), 1'b0);
      addr_i = ~addr_i;  // R8: later addr_i changes must not leak
      for (int k = 0; k < 4; k++) begin
        check(v[10] ? "R3 interleaved beat" : "R4 linear beat", addr_o, up | AW'(ex[k]));
        check("R6 last flag", {15'b0, last_o}, (k == 3) ? 16'd1 : 16'd0);
        tick();
      end
      check("R7 wrap to start", addr_o, up | AW'(v[9:8]));
      check("R7 last cleared", {15'b0, last_o}, '0);
      adv_n_i = 1'b1;
    end

    // R5: hold with advance high, mid-burst
    begin_burst(1'b0, 16'hA5A1, 1'b0);
    tick();
    adv_n_i = 1'b1;
    held = addr_o;
    tick(); tick(); tick();
    check("R5 hold addr", addr_o, held);
    check("R5 hold value", addr_o, 16'hA5A2);

    // R2: start wins over advance; load during a running burst
    adv_n_i = 1'b0;
    begin_burst(1'b1, 16'h1233, 1'b0);
    check("R2 load with adv low", addr_o, 16'h1233);
    check("R2 last low after load", {15'b0, last_o}, '0);
    tick(); tick(); tick();
    check("R2 restart reaches last", {15'b0, last_o}, 16'd1);
    check("R3 start 11 fourth beat", addr_o, 16'h1230);

    // R9: order change mid-burst ignored (linear start 11)
    adv_n_i = 1'b1;
    begin_burst(1'b0, 16'h0003, 1'b0);
    order_i = 1'b1;
    tick();
    check("R9 linear kept beat1", addr_o, 16'h0000);
    tick();
    check("R9 linear kept beat2", addr_o, 16'h0001);

    // R1: reset asserted mid-burst clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 async reset addr", addr_o, '0);
    check("R1 async reset last", {15'b0, last_o}, '0);
    adv_n_i = 1'b1;
    rst_n = 1'b1;
    tick(); tick(); tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule